// File: doc/BRIEF.md
# Per-CPU Private Countdown Timer

A single programmable countdown timer meant to sit next to one processor core. Software programs it through a small word-addressed register bus. There are four 32-bit registers: a reload value, the live count, a control word and a one-bit sticky interrupt status. When the timer is enabled and the count is not zero, the count drops by one every (P + 1) input clocks, where P is an 8-bit prescaler held in the control word.

When the count steps from one to zero, the timer expires. Expiry sets the sticky status flag. In auto-reload mode the count is refilled from the reload register and counting goes on. In one-shot mode the count stays at zero and the timer stops. An interrupt line gives a single-cycle pulse only when the status flag goes from clear to set. While the flag is still set, later expiries give no new pulse. Software clears the flag by writing a one to it.

The bus is a plain register port. A write completes in the cycle it is presented. Read data is combinational from the address, so the port has no back-pressure and no handshake.

Top module: `cpu_private_timer`

## Requirements
- R1: After reset every register reads 0, the interrupt output is low, and a read from any offset other than 0x0, 0x4, 0x8 or 0xC returns 0.
- R2: The reload register sits at offset 0x0, the count at 0x4, the control word at 0x8 and the status at 0xC. Status is bit 0 and the other status bits read 0. The control word reads back exactly as written.
- R3: Control bit 0 enables the timer, bit 1 selects auto-reload, and bits 15:8 hold the prescaler P. A count of N that starts on a clock edge expires on the edge N*(P+1) clocks later.
- R4: In one-shot mode (bit 1 = 0), expiry sets status to 1 and leaves the count at 0. No further expiry follows.
- R5: In auto-reload mode (bit 1 = 1), expiry sets status to 1 and copies the reload register into the count. The next expiry comes after another N*(P+1) clocks.
- R6: A write to offset 0x0 updates the reload register and puts the same value into the count. It also restarts the prescaler, so the timing of R3 starts again from that write edge.
- R7: A write to offset 0x4 sets the count directly and restarts the prescaler. The reload register is not changed.
- R8: When a control write changes bit 0 from 0 to 1 while the count is 0 and the written bit 1 is 1, the count is first loaded from the reload register. Counting then starts from the enable edge.
- R9: The count does not change while the timer is disabled or the count is 0. Reading offset 0x4 returns 0 while the timer is disabled or the count is 0.
- R10: Writing offset 0xC clears status only when data bit 0 is 1. Writing 0 to bit 0 leaves status unchanged.
- R11: The interrupt output is high for exactly one cycle, in the first cycle that status reads 1 after having read 0. It stays low while status remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe; the write takes effect at the next rising edge |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | Single-cycle interrupt pulse on a status rising edge |

## Verification
The bench measures the exact number of cycles from each starting edge to expiry, over random counts, prescaler values and modes. An off-by-one in the prescaler compare, or a prescaler left running after a restart, would change that count. It checks that auto-reload refills the count while the flag stays set and does not pulse again, so a level-sensitive interrupt or a missing reload would show up. It enables the timer with a zero count in both modes: a design that fetched the reload value in one-shot mode, or did not fetch it in auto-reload mode, would expire when it should not, or never expire. It also confirms that status writes with bit 0 clear leave the flag alone, and that a disabled timer holds its count and reads 0.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int unsigned OFS_LOAD  = 32'h0;
  localparam int unsigned OFS_COUNT = 32'h4;
  localparam int unsigned OFS_CTRL  = 32'h8;
  localparam int unsigned OFS_STAT  = 32'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOAD,
    SEL_COUNT,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;

  function automatic reg_sel_e sel_of(input logic [31:0] offs);
    case (offs)
      OFS_LOAD:  return SEL_LOAD;
      OFS_COUNT: return SEL_COUNT;
      OFS_CTRL:  return SEL_CTRL;
      OFS_STAT:  return SEL_STAT;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;
  logic             wrap;

  assign wrap = (div_q >= limit);
  assign tick = run && !restart && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)                div_q <= '0;
    else if (restart || !run)  div_q <= '0;
    else if (wrap)             div_q <= '0;
    else                       div_q <= div_q + PRE_W'(1);
  end

  // R3: no decrement pulse in the cycle that follows a restart
  a_r3_no_tick_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart && limit != '0 |=> !tick);

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_load,
  input  logic              wr_count,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fetch,
  input  logic              auto_mode,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] count,
  output logic              expire
);
  logic [DATA_W-1:0] count_q;
  logic              at_one;

  assign at_one = (count_q == DATA_W'(1));
  assign expire = tick && at_one;
  assign count  = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        count_q <= '0;
    else if (wr_load || wr_count)      count_q <= wdata;
    else if (fetch && count_q == '0)   count_q <= reload_val;
    else if (tick) begin
      if (at_one) count_q <= auto_mode ? reload_val : '0;
      else        count_q <= count_q - DATA_W'(1);
    end
  end

  // R9: with no tick, write or fetch the count holds its value
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick || wr_load || wr_count || fetch) |=> $stable(count_q));

  // R4: one-shot expiry leaves the count at zero
  a_r4_oneshot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !auto_mode && !wr_load && !wr_count |=> count_q == '0);

endmodule

// File: rtl/ptmr_irq_edge.sv
module ptmr_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign pulse = level && !level_d;

  // R11: pulse lasts one cycle
  a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R11: pulse only where the level was low one cycle earlier
  a_r11_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> !$past(level));

endmodule

// File: rtl/cpu_private_timer.sv
module cpu_private_timer
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse
);
  localparam int EN_BIT   = 0;
  localparam int AUTO_BIT = 1;
  localparam int PRE_LSB  = 8;
  localparam int PRE_MSB  = PRE_LSB + PRE_W - 1;

  reg_sel_e          sel;
  logic              wr_load, wr_count, wr_ctrl, wr_stat;
  logic [DATA_W-1:0] reload_q, ctrl_q;
  logic              status_q;
  logic              en_rise, fetch, restart, run;
  logic              tick, expire;
  logic [DATA_W-1:0] count;

  assign sel      = sel_of(32'(bus_addr));
  assign wr_load  = bus_wr && (sel == SEL_LOAD);
  assign wr_count = bus_wr && (sel == SEL_COUNT);
  assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
  assign wr_stat  = bus_wr && (sel == SEL_STAT);

  assign en_rise = wr_ctrl && !ctrl_q[EN_BIT] && bus_wdata[EN_BIT];
  assign fetch   = en_rise && bus_wdata[AUTO_BIT];
  assign restart = wr_load || wr_count || en_rise;
  assign run     = ctrl_q[EN_BIT] && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      status_q <= 1'b0;
    end else begin
      if (wr_load) reload_q <= bus_wdata;
      if (wr_ctrl) ctrl_q   <= bus_wdata;
      if (expire)                        status_q <= 1'b1;
      else if (wr_stat && bus_wdata[0])  status_q <= 1'b0;
    end
  end

  ptmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .limit   (ctrl_q[PRE_MSB:PRE_LSB]),
    .tick    (tick)
  );

  ptmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_load    (wr_load),
    .wr_count   (wr_count),
    .wdata      (bus_wdata),
    .fetch      (fetch),
    .auto_mode  (ctrl_q[AUTO_BIT]),
    .reload_val (reload_q),
    .count      (count),
    .expire     (expire)
  );

  ptmr_irq_edge u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .level (status_q),
    .pulse (irq_pulse)
  );

  always_comb begin
    case (sel)
      SEL_LOAD:  bus_rdata = reload_q;
      SEL_COUNT: bus_rdata = (ctrl_q[EN_BIT] && count != '0) ? count : '0;
      SEL_CTRL:  bus_rdata = ctrl_q;
      SEL_STAT:  bus_rdata = DATA_W'(status_q);
      default:   bus_rdata = '0;
    endcase
  end

  // R10: status falls only after a status write with bit 0 set
  a_r10_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q) |-> $past(wr_stat && bus_wdata[0]));

  // R11: an interrupt pulse is seen only while status is set
  a_r11_pulse_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> status_q);

  // R5: auto-reload expiry refills the count from the reload register
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ctrl_q[AUTO_BIT] && !wr_load && !wr_count |=> count == $past(reload_q));

endmodule

// File: tb/cpu_private_timer_tb_top.sv
module cpu_private_timer_tb_top;
  localparam logic [7:0] A_LOAD = 8'h0, A_CNT = 8'h4, A_CTRL = 8'h8, A_STAT = 8'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cpu_private_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  function automatic int exp_cycles(input int n, input int p);
    return n * (p + 1);
  endfunction

  function automatic logic [31:0] ctrl_word(input bit en, input bit au, input int p);
    return {16'h0, 8'(p), 6'h0, au, en};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int limit, output int k);
    k = 0;
    while (k < limit) begin
      @(posedge clk); #1;
      k++;
      if (irq_pulse) break;
    end
  endtask

  task automatic quiet(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (irq_pulse) seen = 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int k;
    bit seen;
    void'($urandom(32'h1d5e_0c4a));

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_LOAD, v); check(v == 0, "R1 load", v, 0);
    rd(A_CNT, v);  check(v == 0, "R1 count", v, 0);
    rd(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
    rd(A_STAT, v); check(v == 0, "R1 status", v, 0);
    check(irq_pulse == 0, "R1 irq", irq_pulse, 0);

    // R2 control readback, R1 unused offset
    wr(A_CTRL, 32'h0000_3502);
    rd(A_CTRL, v); check(v == 32'h3502, "R2 ctrl readback", v, 32'h3502);
    wr(A_LOAD, 32'h77);
    rd(8'h10, v); check(v == 0, "R1 unused 0x10", v, 0);
    rd(8'h14, v); check(v == 0, "R1 unused 0x14", v, 0);

    // R9 disabled: count holds, reads 0
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'd9);
    rd(A_LOAD, v); check(v == 9, "R2 load readback", v, 9);
    rd(A_CNT, v); check(v == 0, "R9 count reads 0 when disabled", v, 0);
    quiet(15, seen); check(!seen, "R9 no expiry while disabled", seen, 0);
    wr(A_CTRL, ctrl_word(1, 0, 0));
    wait_irq(100, k); check(k == 9, "R9 count held, expiry after enable", k, 9);
    check(irq_pulse == 1, "R11 pulse on rise", irq_pulse, 1);
    @(posedge clk); #1;
    check(irq_pulse == 0, "R11 pulse one cycle", irq_pulse, 0);
    rd(A_STAT, v); check(v == 1, "R4 status set", v, 1);

    // R10 write-one-to-clear
    wr(A_STAT, 32'hFFFF_FFFE);
    rd(A_STAT, v); check(v == 1, "R10 write 0 keeps status", v, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check(v == 0, "R10 write 1 clears", v, 0);

    // R6 load write sets live count; mid-count read
    wr(A_LOAD, 32'd10);
    repeat (3) begin @(posedge clk); #1; end
    rd(A_CNT, v); check(v == 7, "R6 count from load write", v, 7);
    wr(A_LOAD, 32'd4);
    wait_irq(100, k); check(k == 4, "R6 load write restarts", k, 4);
    wr(A_STAT, 32'h1);

    // R7 count write restarts, reload untouched
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, ctrl_word(1, 0, 3));
    wr(A_LOAD, 32'd5);
    repeat (6) begin @(posedge clk); #1; end
    wr(A_CNT, 32'd2);
    rd(A_LOAD, v); check(v == 5, "R7 reload unchanged", v, 5);
    wait_irq(100, k); check(k == exp_cycles(2, 3), "R7 count write restarts", k, exp_cycles(2, 3));
    wr(A_STAT, 32'h1);

    // R8 enable with zero count, auto-reload fetches
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'd6);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, ctrl_word(1, 1, 0));
    rd(A_CNT, v); check(v == 6, "R8 fetch on enable", v, 6);
    wait_irq(100, k); check(k == 6, "R8 expiry after fetch", k, 6);
    wr(A_STAT, 32'h1);

    // R8/R9 one-shot enable with zero count does nothing
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, ctrl_word(1, 0, 0));
    rd(A_CNT, v); check(v == 0, "R8 no fetch in one-shot", v, 0);
    quiet(20, seen); check(!seen, "R9 zero count does not run", seen, 0);
    rd(A_STAT, v); check(v == 0, "R9 status untouched", v, 0);

    // R3 R4 R5 R11 random runs
    for (int it = 0; it < 14; it++) begin
      int n, p, e;
      bit au;
      n  = $urandom_range(1, 12);
      p  = $urandom_range(0, 5);
      au = 1'($urandom_range(0, 1));
      e  = exp_cycles(n, p);
      wr(A_CTRL, 32'h0);
      wr(A_STAT, 32'h1);
      wr(A_LOAD, n);
      wr(A_CTRL, ctrl_word(1, au, p));
      wait_irq(e + 20, k);
      check(k == e, "R3 expiry timing", k, e);
      rd(A_STAT, v); check(v == 1, "R4 R5 status set", v, 1);
      rd(A_CNT, v);
      if (au) begin
        check(v == n, "R5 reload after expiry", v, n);
        quiet(e, seen);
        check(!seen, "R11 no pulse while status high", seen, 0);
        rd(A_CNT, v); check(v == n, "R5 second reload", v, n);
        wr(A_STAT, 32'h1);
        wait_irq(e + 20, k);
        check(k == e - 1, "R11 pulse after clear", k, e - 1);
      end else begin
        check(v == 0, "R4 one-shot count zero", v, 0);
        quiet(20, seen);
        check(!seen, "R4 one-shot stops", seen, 0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule